// File: doc/BRIEF.md
# Flash Array Erase Sequencer

This controller sits behind a flash command decoder and carries out an erase of either the whole array or a chosen set of sectors with no further help from the host. A one-cycle start strobe selects chip mode or a sector mask. The controller first drives every word of the target region to all zeros and reads each one back. It then applies erase pulses that it times itself. After each pulse it walks the region looking for words that still hold a zero bit, and it repeats pulse and walk until the region reads erased or a pulse budget runs out.

The array connects through a plain port: a one-cycle program strobe that clears the addressed word, a level erase enable with a sector mask, and a combinational read of the addressed word. Words are grouped into sectors by the top address bits. A suspend request makes the controller park at the next point between pulses. A resume request restarts it from the same pulse count and verify position.

Top module: `flash_erase_seq`

## Requirements
- R1: While reset is asserted and after reset, busy, fail, arr_prog and arr_erase are low.
- R2: A start strobe is accepted only in the idle state and only with chip_mode high or a non-zero sect_mask, and busy rises on the next cycle. A start with an empty mask in sector mode, a start while busy, and a start while suspended are ignored.
- R3: Pre-programming visits every word of the target region in ascending address order. Each word gets one cycle with arr_prog high and arr_addr on the word, then one read-back cycle at the same address. Sector s holds the words whose upper SECT_W address bits equal s, and words of unselected sectors are never programmed.
- R4: If a pre-program read-back returns a non-zero word, the controller drops busy and raises fail without issuing any erase pulse.
- R5: Each erase pulse holds arr_erase high for exactly CHIP_PULSE_CYC consecutive cycles in chip mode, or SECT_PULSE_CYC cycles in sector mode. During the pulse arr_sect_mask is all ones in chip mode and equals the latched sector mask otherwise.
- R6: After each pulse the controller reads the region one word per cycle in ascending order. It starts at the first word not yet confirmed erased and stops at the first word that is not all ones. If the limit is not reached and no suspend is taken, the next pulse starts on the following cycle.
- R7: When the last word of the region reads all ones, busy drops with fail low.
- R8: If the read-back still fails after the MAX_PULSES-th pulse, busy drops and fail rises.
- R9: A suspend request seen on any busy cycle is held. It takes effect only when a post-pulse read-back fails below the limit, and then busy drops with no array activity. A pass or a limit failure takes precedence, and a suspend request while idle or suspended is ignored.
- R10: A resume request while suspended starts the next pulse on the following cycle. The pulse count and verify position are kept from before the suspend.
- R11: fail stays high until the next accepted start, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle request to begin an erase |
| chip_mode | input | 1 | High: whole array; low: use sect_mask |
| sect_mask | input | SECTORS | Sectors to erase in sector mode, bit s for sector s |
| susp_req | input | 1 | Request to park between pulses |
| resume | input | 1 | Continue a parked erase |
| arr_rdata | input | DATA_W | Combinational read data of the word at arr_addr |
| busy | output | 1 | Operation in progress |
| fail | output | 1 | Last operation failed (pre-program or pulse limit) |
| arr_prog | output | 1 | Program word at arr_addr to all zeros |
| arr_erase | output | 1 | Erase pulse active on sectors in arr_sect_mask |
| arr_sect_mask | output | SECTORS | Sectors targeted by the operation |
| arr_addr | output | ADDR_W | Word address for program and read-back |

## Verification
A corrupted address walk shows up on arr_addr in the very next program or read-back cycle. The bench compares that address every cycle, so a skipped or repeated word is caught at once. A wrong pulse timer shows as an arr_erase level that ends one cycle early or late. A wrong pulse counter or a lost suspend flag only shows when a read-back fails: as an extra or missing pulse, a fail raised too early or too late, or busy failing to drop at the suspend point. The scenarios are therefore built with sectors that need several pulses and with suspend requests placed before failing and before passing read-backs.

// File: rtl/esq_pkg.sv
package esq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PROG  = 3'd1,
    ST_PVFY  = 3'd2,
    ST_ERASE = 3'd3,
    ST_EVFY  = 3'd4,
    ST_SUSP  = 3'd5
  } esq_state_e;

  function automatic logic state_is_busy(input esq_state_e s);
    return (s == ST_PROG) || (s == ST_PVFY) || (s == ST_ERASE) || (s == ST_EVFY);
  endfunction

endpackage

// File: rtl/esq_region_walk.sv
module esq_region_walk #(
  parameter int ADDR_W = 6,
  parameter int SECT_W = 2
) (
  input  logic [ADDR_W-1:0]      cur_addr,
  input  logic [(1<<SECT_W)-1:0] sel_mask,
  output logic [ADDR_W-1:0]      first_addr,
  output logic [ADDR_W-1:0]      next_addr,
  output logic                   at_last,
  output logic                   any_sel
);

  localparam int NSECT = 1 << SECT_W;
  localparam int OFF_W = ADDR_W - SECT_W;

  logic [SECT_W-1:0] cur_sec;
  logic [OFF_W-1:0]  cur_off;
  logic [SECT_W-1:0] first_sec;
  logic [SECT_W-1:0] follow_sec;
  logic              have_follow;

  assign cur_sec = cur_addr[ADDR_W-1 -: SECT_W];
  assign cur_off = cur_addr[OFF_W-1:0];

  // lowest selected sector overall
  always_comb begin
    first_sec = '0;
    any_sel   = 1'b0;
    for (int s = NSECT - 1; s >= 0; s--) begin
      if (sel_mask[s]) begin
        first_sec = SECT_W'(s);
        any_sel   = 1'b1;
      end
    end
  end

  // lowest selected sector above the current one
  always_comb begin
    follow_sec  = '0;
    have_follow = 1'b0;
    for (int s = NSECT - 1; s >= 0; s--) begin
      if (sel_mask[s] && (s > int'(cur_sec))) begin
        follow_sec  = SECT_W'(s);
        have_follow = 1'b1;
      end
    end
  end

  always_comb begin
    first_addr = {first_sec, {OFF_W{1'b0}}};
    if (cur_off != {OFF_W{1'b1}}) begin
      next_addr = cur_addr + 1'b1;
      at_last   = 1'b0;
    end else begin
      next_addr = {follow_sec, {OFF_W{1'b0}}};
      at_last   = !have_follow;
    end
  end

endmodule

// File: rtl/esq_pulse_timer.sv
module esq_pulse_timer #(
  parameter int unsigned CHIP_PULSE_CYC = 2_000_000,
  parameter int unsigned SECT_PULSE_CYC = 2_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic use_chip,
  input  logic run,
  output logic expired
);

  localparam int unsigned MAXC = (CHIP_PULSE_CYC > SECT_PULSE_CYC) ? CHIP_PULSE_CYC : SECT_PULSE_CYC;
  localparam int          TW   = $clog2(MAXC + 1);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = use_chip ? TW'(CHIP_PULSE_CYC - 1) : TW'(SECT_PULSE_CYC - 1);
    end else if (run && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = run && (cnt_q == '0);

  AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TW'(MAXC - 1)) else $error("timer above pulse width"); // R5

  AST_TMR_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && !expired) |=> (cnt_q == $past(cnt_q) - 1'b1)) else $error("timer stalled in pulse"); // R5

endmodule

// File: rtl/esq_ctrl.sv
module esq_ctrl
  import esq_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int SECT_W     = 2,
  parameter int DATA_W     = 8,
  parameter int MAX_PULSES = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   chip_mode,
  input  logic [(1<<SECT_W)-1:0] sect_mask,
  input  logic                   susp_req,
  input  logic                   resume,
  input  logic [DATA_W-1:0]      arr_rdata,
  input  logic                   tmr_expired,
  input  logic [ADDR_W-1:0]      walk_first,
  input  logic [ADDR_W-1:0]      walk_next,
  input  logic                   walk_last,
  input  logic                   walk_any,
  output logic [(1<<SECT_W)-1:0] walk_mask,
  output logic                   tmr_load,
  output logic                   tmr_chip,
  output logic                   tmr_run,
  output logic                   busy,
  output logic                   fail,
  output logic                   arr_prog,
  output logic                   arr_erase,
  output logic [(1<<SECT_W)-1:0] arr_sect_mask,
  output logic [ADDR_W-1:0]      arr_addr
);

  localparam int NSECT = 1 << SECT_W;
  localparam int PCW   = $clog2(MAX_PULSES + 1);

  esq_state_e        st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_en;
  logic [PCW-1:0]    pcnt_q, pcnt_d;
  logic              pcnt_en;
  logic [NSECT-1:0]  mask_q, mask_d;
  logic              chip_q, chip_d;
  logic              cfg_en;
  logic              fail_q, fail_d;
  logic              pend_q, pend_d;
  logic [NSECT-1:0]  eff_mask;
  logic              busy_now, busy_nxt;
  logic              word_zero, word_ones;

  assign eff_mask  = chip_mode ? {NSECT{1'b1}} : sect_mask;
  assign walk_mask = (st_q == ST_IDLE) ? eff_mask : mask_q;
  assign word_zero = (arr_rdata == '0);
  assign word_ones = (arr_rdata == '1);
  assign busy_now  = state_is_busy(st_q);
  assign busy_nxt  = state_is_busy(st_d);

  // next-state logic
  always_comb begin
    st_d     = st_q;
    addr_d   = addr_q;
    addr_en  = 1'b0;
    pcnt_d   = pcnt_q;
    pcnt_en  = 1'b0;
    mask_d   = mask_q;
    chip_d   = chip_q;
    cfg_en   = 1'b0;
    fail_d   = fail_q;
    tmr_load = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start && walk_any) begin
          st_d    = ST_PROG;
          addr_d  = walk_first;
          addr_en = 1'b1;
          pcnt_d  = '0;
          pcnt_en = 1'b1;
          mask_d  = eff_mask;
          chip_d  = chip_mode;
          cfg_en  = 1'b1;
          fail_d  = 1'b0;
        end
      end
      ST_PROG: begin
        st_d = ST_PVFY;
      end
      ST_PVFY: begin
        if (!word_zero) begin
          st_d   = ST_IDLE;
          fail_d = 1'b1;
        end else if (walk_last) begin
          st_d     = ST_ERASE;
          addr_d   = walk_first;
          addr_en  = 1'b1;
          tmr_load = 1'b1;
        end else begin
          st_d    = ST_PROG;
          addr_d  = walk_next;
          addr_en = 1'b1;
        end
      end
      ST_ERASE: begin
        if (tmr_expired) begin
          st_d    = ST_EVFY;
          pcnt_d  = pcnt_q + 1'b1;
          pcnt_en = 1'b1;
        end
      end
      ST_EVFY: begin
        if (!word_ones) begin
          if (pcnt_q == PCW'(MAX_PULSES)) begin
            st_d   = ST_IDLE;
            fail_d = 1'b1;
          end else if (pend_q || susp_req) begin
            st_d = ST_SUSP;
          end else begin
            st_d     = ST_ERASE;
            tmr_load = 1'b1;
          end
        end else if (walk_last) begin
          st_d = ST_IDLE;
        end else begin
          addr_d  = walk_next;
          addr_en = 1'b1;
        end
      end
      ST_SUSP: begin
        if (resume) begin
          st_d     = ST_ERASE;
          tmr_load = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    pend_d = busy_nxt ? (pend_q || (busy_now && susp_req)) : 1'b0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      fail_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      fail_q <= fail_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
    end else if (pcnt_en) begin
      pcnt_q <= pcnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      chip_q <= 1'b0;
    end else if (cfg_en) begin
      mask_q <= mask_d;
      chip_q <= chip_d;
    end
  end

  assign tmr_chip      = chip_q;
  assign tmr_run       = (st_q == ST_ERASE);
  assign busy          = busy_now;
  assign fail          = fail_q;
  assign arr_prog      = (st_q == ST_PROG);
  assign arr_erase     = (st_q == ST_ERASE);
  assign arr_sect_mask = mask_q;
  assign arr_addr      = addr_q;

  AST_FAIL_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> !busy) else $error("fail while busy"); // R11

  AST_PCNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt_q <= PCW'(MAX_PULSES)) else $error("pulse count past limit"); // R8

  AST_PROG_THEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    arr_prog |=> (!arr_prog && !arr_erase && busy && $stable(arr_addr))) else $error("program not followed by read-back"); // R3

  AST_ERASE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arr_erase) |-> ($past(st_q) inside {ST_PVFY, ST_EVFY, ST_SUSP})) else $error("pulse without pre-program"); // R5

  AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(arr_sect_mask)) else $error("mask changed mid-operation"); // R5

  AST_WALK_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_EVFY && word_ones && !walk_last) |=> (arr_addr > $past(arr_addr))) else $error("verify walk not ascending"); // R6

  AST_RESUME_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SUSP && resume) |=> (arr_erase && $stable(arr_addr))) else $error("resume lost position"); // R10

  AST_PROG_ERASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(arr_prog && arr_erase)) else $error("program and erase together"); // R3

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq #(
  parameter int          ADDR_W         = 6,
  parameter int          SECT_W         = 2,
  parameter int          DATA_W         = 8,
  parameter int unsigned CHIP_PULSE_CYC = 2_000_000,
  parameter int unsigned SECT_PULSE_CYC = 2_000_000,
  parameter int          MAX_PULSES     = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   chip_mode,
  input  logic [(1<<SECT_W)-1:0] sect_mask,
  input  logic                   susp_req,
  input  logic                   resume,
  input  logic [DATA_W-1:0]      arr_rdata,
  output logic                   busy,
  output logic                   fail,
  output logic                   arr_prog,
  output logic                   arr_erase,
  output logic [(1<<SECT_W)-1:0] arr_sect_mask,
  output logic [ADDR_W-1:0]      arr_addr
);

  localparam int NSECT = 1 << SECT_W;

  logic [1:0]        rsync_q;
  logic              core_rst_n;
  logic [NSECT-1:0]  walk_mask;
  logic [ADDR_W-1:0] walk_first;
  logic [ADDR_W-1:0] walk_next;
  logic              walk_last;
  logic              walk_any;
  logic              tmr_load;
  logic              tmr_chip;
  logic              tmr_run;
  logic              tmr_expired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= '0;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end

  assign core_rst_n = rsync_q[1];

  esq_region_walk #(
    .ADDR_W (ADDR_W),
    .SECT_W (SECT_W)
  ) walk_i (
    .cur_addr   (arr_addr),
    .sel_mask   (walk_mask),
    .first_addr (walk_first),
    .next_addr  (walk_next),
    .at_last    (walk_last),
    .any_sel    (walk_any)
  );

  esq_pulse_timer #(
    .CHIP_PULSE_CYC (CHIP_PULSE_CYC),
    .SECT_PULSE_CYC (SECT_PULSE_CYC)
  ) timer_i (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .load     (tmr_load),
    .use_chip (tmr_chip),
    .run      (tmr_run),
    .expired  (tmr_expired)
  );

  esq_ctrl #(
    .ADDR_W     (ADDR_W),
    .SECT_W     (SECT_W),
    .DATA_W     (DATA_W),
    .MAX_PULSES (MAX_PULSES)
  ) ctrl_i (
    .clk           (clk),
    .rst_n         (core_rst_n),
    .start         (start),
    .chip_mode     (chip_mode),
    .sect_mask     (sect_mask),
    .susp_req      (susp_req),
    .resume        (resume),
    .arr_rdata     (arr_rdata),
    .tmr_expired   (tmr_expired),
    .walk_first    (walk_first),
    .walk_next     (walk_next),
    .walk_last     (walk_last),
    .walk_any      (walk_any),
    .walk_mask     (walk_mask),
    .tmr_load      (tmr_load),
    .tmr_chip      (tmr_chip),
    .tmr_run       (tmr_run),
    .busy          (busy),
    .fail          (fail),
    .arr_prog      (arr_prog),
    .arr_erase     (arr_erase),
    .arr_sect_mask (arr_sect_mask),
    .arr_addr      (arr_addr)
  );

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!core_rst_n)
    $rose(core_rst_n) |-> (!busy && !fail && !arr_prog && !arr_erase)) else $error("active out of reset"); // R1

endmodule

// File: tb/flash_erase_seq_tb.sv
`timescale 1ns/1ps
module flash_erase_seq_tb_top;

  localparam int AW = 6;
  localparam int SW = 2;
  localparam int DW = 8;
  localparam int NS = 4;
  localparam int WORDS = 64;
  localparam int SECT_WORDS = 16;
  localparam int CP = 12;
  localparam int SP = 7;
  localparam int MP = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic          start = 1'b0;
  logic          chip_mode = 1'b0;
  logic [NS-1:0] sect_mask = '0;
  logic          susp_req = 1'b0;
  logic          resume = 1'b0;
  logic [DW-1:0] arr_rdata;
  logic          busy, fail, arr_prog, arr_erase;
  logic [NS-1:0] arr_sect_mask;
  logic [AW-1:0] arr_addr;

  int n_tests = 0;
  int n_fail  = 0;

  flash_erase_seq #(
    .ADDR_W(AW), .SECT_W(SW), .DATA_W(DW),
    .CHIP_PULSE_CYC(CP), .SECT_PULSE_CYC(SP), .MAX_PULSES(MP)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .chip_mode(chip_mode),
    .sect_mask(sect_mask), .susp_req(susp_req), .resume(resume),
    .arr_rdata(arr_rdata), .busy(busy), .fail(fail), .arr_prog(arr_prog),
    .arr_erase(arr_erase), .arr_sect_mask(arr_sect_mask), .arr_addr(arr_addr)
  );

  // behavioural array: erase counts pulse cycles per sector
  logic [DW-1:0] mem [WORDS];
  int  need [NS];
  int  ecyc [NS];
  int  stuck = -1;
  int  cur_p = CP;
  logic setup_req = 1'b0;

  assign arr_rdata = mem[arr_addr];

  always @(posedge clk) begin
    if (setup_req) begin
      for (int a = 0; a < WORDS; a++) mem[a] <= DW'(8'h3C + a);
      for (int s = 0; s < NS; s++) ecyc[s] <= 0;
    end else begin
      if (arr_prog && (int'(arr_addr) != stuck)) mem[arr_addr] <= '0;
      if (arr_erase) begin
        for (int s = 0; s < NS; s++) begin
          if (arr_sect_mask[s]) begin
            ecyc[s] <= ecyc[s] + 1;
            if (ecyc[s] + 1 == need[s] * cur_p)
              for (int o = 0; o < SECT_WORDS; o++) mem[s*SECT_WORDS + o] <= '1;
          end
        end
      end
    end
  end

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // reference model
  logic          em_busy = 0, em_fail = 0, em_prog = 0, em_erase = 0;
  logic [AW-1:0] em_addr = '0;
  logic [NS-1:0] em_mask = '0;
  logic          em_active = 0, em_susp = 0;
  logic          pend = 0;
  logic          chk_en = 0;
  string         em_tag = "R1";

  task automatic tick();
    @(posedge clk);
    pend = pend | susp_req;
  endtask

  task automatic model_run(input logic ch, input logic [NS-1:0] m);
    int q[$];
    int vi;
    int pulses;
    int plen;
    for (int s = 0; s < NS; s++)
      if (ch || m[s])
        for (int o = 0; o < SECT_WORDS; o++) q.push_back(s*SECT_WORDS + o);
    plen = ch ? CP : SP;
    em_active = 1; em_busy = 1; em_fail = 0; em_mask = ch ? '1 : m; pend = 0;
    for (int i = 0; i < q.size(); i++) begin
      em_tag = "R3";
      em_prog = 1; em_addr = AW'(q[i]);
      tick();
      em_prog = 0;
      tick();
      if (mem[q[i]] !== '0) begin
        em_busy = 0; em_fail = 1; em_tag = "R4"; em_active = 0;
        return;
      end
    end
    vi = 0; pulses = 0;
    forever begin
      if (em_tag != "R10") em_tag = "R5";
      em_erase = 1; em_addr = AW'(q[vi]);
      repeat (plen) tick();
      pulses++;
      em_erase = 0;
      em_tag = "R6";
      forever begin
        em_addr = AW'(q[vi]);
        tick();
        if (mem[q[vi]] !== '1) break;
        vi++;
        if (vi == q.size()) begin
          em_busy = 0; em_tag = "R7"; em_active = 0;
          return;
        end
      end
      if (pulses == MP) begin
        em_busy = 0; em_fail = 1; em_tag = "R8"; em_active = 0;
        return;
      end
      if (pend) begin
        em_busy = 0; em_susp = 1; pend = 0; em_tag = "R9";
        do @(posedge clk); while (!resume);
        em_susp = 0; em_busy = 1; em_tag = "R10";
      end
    end
  endtask

  initial begin
    wait (chk_en);
    forever begin
      @(posedge clk);
      if (start && (chip_mode || sect_mask != '0)) model_run(chip_mode, sect_mask);
      else if (em_fail) em_tag = "R11";
      else em_tag = "R2";
    end
  end

  always @(negedge clk) begin
    if (chk_en) begin
      check(em_tag, "busy", 32'(busy), 32'(em_busy));
      check(em_tag, "fail", 32'(fail), 32'(em_fail));
      check(em_tag, "arr_prog", 32'(arr_prog), 32'(em_prog));
      check(em_tag, "arr_erase", 32'(arr_erase), 32'(em_erase));
      if (em_busy) check(em_tag, "arr_addr", 32'(arr_addr), 32'(em_addr));
      if (em_erase) check(em_tag, "arr_sect_mask", 32'(arr_sect_mask), 32'(em_mask));
    end
  end

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    finish_run();
  end

  task automatic setup(input int n0, input int n1, input int n2, input int n3, input int stk, input logic ch);
    need[0] = n0; need[1] = n1; need[2] = n2; need[3] = n3;
    stuck = stk; cur_p = ch ? CP : SP;
    @(negedge clk); setup_req = 1;
    @(negedge clk); setup_req = 0;
  endtask

  task automatic pulse_start(input logic ch, input logic [NS-1:0] m);
    @(negedge clk); chip_mode = ch; sect_mask = m; start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic pulse_susp();
    @(negedge clk); susp_req = 1;
    @(negedge clk); susp_req = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (em_active);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    rst_n = 0;
    repeat (4) @(negedge clk);
    // R1: outputs quiet in reset
    check("R1", "busy in reset", 32'(busy), 0);
    check("R1", "fail in reset", 32'(fail), 0);
    check("R1", "arr_prog in reset", 32'(arr_prog), 0);
    check("R1", "arr_erase in reset", 32'(arr_erase), 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk_en = 1;

    // chip erase, sectors need 1,2,1,3 pulses; a second start mid-run is ignored (R2)
    setup(1, 2, 1, 3, -1, 1'b1);
    pulse_start(1'b1, 4'hF);
    repeat (40) @(negedge clk);
    pulse_start(1'b0, 4'b0010);
    wait_idle();
    check("R7", "chip pass fail", 32'(fail), 0);
    check("R5", "chip erased word", 32'(mem[63]), 32'hFF);

    // sector mode, sectors 0 and 2
    setup(2, 1, 1, 1, -1, 1'b0);
    pulse_start(1'b0, 4'b0101);
    wait_idle();
    check("R7", "sector pass fail", 32'(fail), 0);
    check("R3", "unselected word kept", 32'(mem[20]), 32'(8'h3C + 20));
    check("R3", "unselected word kept hi", 32'(mem[63]), 32'(8'h3C + 63));
    check("R6", "selected word erased", 32'(mem[40]), 32'hFF);

    // empty mask in sector mode is ignored
    pulse_start(1'b0, 4'b0000);
    repeat (3) @(negedge clk);
    check("R2", "empty mask busy", 32'(busy), 0);

    // pulse limit
    setup(1, 1, 1, 5, -1, 1'b0);
    pulse_start(1'b0, 4'b1000);
    wait_idle();
    check("R8", "limit fail", 32'(fail), 1);
    repeat (5) @(negedge clk);
    check("R11", "fail held", 32'(fail), 1);

    // stuck word during pre-program; start clears old fail
    setup(1, 1, 1, 1, 20, 1'b0);
    pulse_start(1'b0, 4'b0010);
    check("R11", "fail cleared on start", 32'(fail), 0);
    wait_idle();
    check("R4", "pre-program fail", 32'(fail), 1);

    // suspend between pulses, ignored start and suspend while parked, resume
    setup(1, 1, 3, 1, -1, 1'b1);
    pulse_start(1'b1, 4'hF);
    repeat (10) @(negedge clk);
    pulse_susp();
    do @(negedge clk); while (!em_susp);
    check("R9", "suspended busy", 32'(busy), 0);
    repeat (3) @(negedge clk);
    pulse_start(1'b0, 4'b0001);
    pulse_susp();
    repeat (3) @(negedge clk);
    check("R2", "start while parked", 32'(busy), 0);
    @(negedge clk); resume = 1;
    @(negedge clk); resume = 0;
    check("R10", "resumed pulse", 32'(arr_erase), 1);
    wait_idle();
    check("R10", "resume pass fail", 32'(fail), 0);

    // suspend pending but read-back passes: pass wins
    setup(1, 1, 1, 1, -1, 1'b0);
    pulse_start(1'b0, 4'b0001);
    repeat (35) @(negedge clk);
    pulse_susp();
    wait_idle();
    check("R9", "pass over suspend busy", 32'(busy), 0);
    check("R9", "pass over suspend fail", 32'(fail), 0);

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule